// File: doc/BRIEF.md
# Indirect Map RAM Access Port

This block holds the 16-word byte-map RAM that an audio multiplexer reads when it builds each output frame, and gives software indirect access to that RAM through two registers instead of a direct memory window. The control register carries the word address, an arm/start bit, a read/write select and a busy flag. The data register is where software places write data and where read data comes back.

Software loads an address, arms the port, and then issues the access. While the port moves data between the data register and the RAM it reports busy, and it ignores every register write until the access ends. Each finished access advances the address by one, modulo the depth, so the whole RAM can be loaded or dumped with no further address writes. A separate combinational lookup port lets the multiplexer read any map word at any time.

Control word layout: bit 31 busy (read only), bit 14 read/write select (1 = write), bit 12 arm/start, bits 5:0 address field, of which the low four bits are kept. All other bits read as zero.

Top module: `amxm_port`

## Requirements
- R1: After reset the control word and the data word read as 0, and every RAM word read through the lookup port is 0.
- R2: A control write with bit 12 = 0 loads the address as bits 5:0 modulo 16, records bit 14 and disarms the port. Readback shows the address in bits 3:0 and busy = 0.
- R3: A control write with bit 12 = 1 while the port is disarmed only arms it: bit 12 then reads 1, the address is unchanged and no access starts (busy stays 0).
- R4: A control write with bits 12 and 14 set while armed starts a write. Busy (bit 31) reads 1 for exactly two cycles, and when it clears the RAM word at the current address holds the data register value.
- R5: A control write with bit 12 set and bit 14 clear while armed starts a read. Busy reads 1 for exactly two cycles, and in the second busy cycle the data register already shows the addressed RAM word.
- R6: Each finished access advances the address by one modulo 16 and leaves the port armed, so further accesses stream through consecutive words.
- R7: Every register write that arrives while busy reads 1 is ignored: it changes neither the address, the arm state, the read/write bit nor the data register.
- R8: A data-register write while idle is read back unchanged and does not alter the RAM until a write access runs.
- R9: The lookup port returns the RAM word selected by the lookup index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 data |
| reg_wdata | input | 32 | Register write value |
| reg_rsel | input | 1 | Read target: 0 control, 1 data |
| reg_rdata | output | 32 | Selected register value |
| map_idx | input | 4 | Lookup index from the multiplexer |
| map_word | output | 32 | RAM word at the lookup index |

## Verification
The RAM is filled by a streamed write of all 16 words with an arithmetic pattern, then dumped by a streamed read that starts at a middle address and wraps past the top. The pattern tells each word apart, so a stuck or misordered address shows up as a wrong value at a known word. Single accesses at an address field above 15 check the modulo wrap of both the load and the increment. Writes to the control and data registers placed inside a busy window separate real ignoring from a late apply, and the busy flag is sampled in every cycle of each access to pin down its two-cycle length and the point at which read data appears.

// File: rtl/amxm_pkg.sv
package amxm_pkg;

    parameter int unsigned MAP_DEPTH    = 16;
    parameter int unsigned WORD_W       = 32;
    parameter int unsigned ACC_LAT      = 2;
    parameter int unsigned ADDR_FIELD_W = 6;

    localparam int unsigned MAP_AW   = $clog2(MAP_DEPTH);
    localparam int unsigned BUSY_BIT = 31;
    localparam int unsigned RW_BIT   = 14;
    localparam int unsigned INIT_BIT = 12;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } acc_op_e;

    typedef struct packed {
        logic [MAP_AW-1:0] addr;
        logic              rw;
        logic              armed;
    } ctl_state_t;

    function automatic logic [31:0] ctl_word(input logic busy, input ctl_state_t st);
        logic [31:0] w;
        w               = '0;
        w[BUSY_BIT]     = busy;
        w[RW_BIT]       = st.rw;
        w[INIT_BIT]     = st.armed;
        w[MAP_AW-1:0]   = st.addr;
        return w;
    endfunction

endpackage

// File: rtl/amxm_map_store.sv
module amxm_map_store #(
    parameter int unsigned DEPTH = amxm_pkg::MAP_DEPTH,
    parameter int unsigned W     = amxm_pkg::WORD_W,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R4
    ram_commit_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/amxm_access_seq.sv
module amxm_access_seq
    import amxm_pkg::*;
#(
    parameter int unsigned LAT = amxm_pkg::ACC_LAT,
    localparam int unsigned CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  acc_op_e op,
    output logic    busy,
    output logic    capture,
    output logic    commit,
    output logic    done
);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    acc_op_e          op_q;

    assign busy    = busy_q;
    assign done    = busy_q && (cnt_q == CNT_W'(LAT - 1));
    assign capture = busy_q && (op_q == OP_READ) && (cnt_q == CNT_W'(LAT - 2));
    assign commit  = done && (op_q == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_READ;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                op_q   <= op;
            end
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |=> busy_q);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |=> !busy_q);

    // R5
    capture_inside_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> busy_q);

endmodule

// File: rtl/amxm_port.sv
module amxm_port
    import amxm_pkg::*;
#(
    parameter int unsigned DEPTH = amxm_pkg::MAP_DEPTH,
    parameter int unsigned LAT   = amxm_pkg::ACC_LAT,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          reg_rsel,
    output logic [31:0]   reg_rdata,
    input  logic [AW-1:0] map_idx,
    output logic [31:0]   map_word
);

    ctl_state_t  ctl_q;
    logic [31:0] data_q;
    logic [31:0] acc_rdata;
    logic        busy, capture, commit, done;
    logic        wr_ok, ctl_wr, dat_wr, start;
    logic        w_init, w_rw;
    acc_op_e     start_op;

    assign w_init   = reg_wdata[INIT_BIT];
    assign w_rw     = reg_wdata[RW_BIT];
    assign wr_ok    = reg_wr && !busy;
    assign ctl_wr   = wr_ok && (reg_sel == 1'b0);
    assign dat_wr   = wr_ok && (reg_sel == 1'b1);
    assign start    = ctl_wr && w_init && ctl_q.armed;
    assign start_op = w_rw ? OP_WRITE : OP_READ;

    amxm_access_seq #(.LAT(LAT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op      (start_op),
        .busy    (busy),
        .capture (capture),
        .commit  (commit),
        .done    (done)
    );

    amxm_map_store #(.DEPTH(DEPTH), .W(32)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (commit),
        .waddr   (ctl_q.addr),
        .wdata   (data_q),
        .raddr_a (ctl_q.addr),
        .rdata_a (acc_rdata),
        .raddr_b (map_idx),
        .rdata_b (map_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.rw <= w_rw;
            if (!w_init) begin
                ctl_q.addr  <= AW'(reg_wdata[ADDR_FIELD_W-1:0]);
                ctl_q.armed <= 1'b0;
            end else begin
                ctl_q.armed <= 1'b1;
            end
        end else if (done) begin
            ctl_q.addr <= ctl_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (dat_wr) begin
            data_q <= reg_wdata;
        end else if (capture) begin
            data_q <= acc_rdata;
        end
    end

    assign reg_rdata = reg_rsel ? data_q : ctl_word(busy, ctl_q);

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7
    armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr) |=> $stable(ctl_q.armed) && $stable(ctl_q.rw));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ctl_q.addr == AW'($past(ctl_q.addr) + 1'b1));

    // R6
    stay_armed_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ctl_q.armed);

endmodule

// File: tb/tb_amxm_port.sv
module tb_amxm_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rsel = 1'b0;
    logic [31:0] reg_rdata;
    logic [3:0]  map_idx = '0;
    logic [31:0] map_word;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    localparam logic [31:0] INIT = 32'h0000_1000;
    localparam logic [31:0] RWB  = 32'h0000_4000;
    localparam logic [31:0] BUSY = 32'h8000_0000;

    always #10 clk = ~clk;

    amxm_port dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .map_idx(map_idx), .map_word(map_word)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'h1357_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    function automatic logic [31:0] cexp(input bit b, input bit rw, input bit arm, input int a);
        return (b ? BUSY : 0) | (rw ? RWB : 0) | (arm ? INIT : 0) | 32'(a % 16);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input bit sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input bit sel, output logic [31:0] v);
        reg_rsel = sel; #1; v = reg_rdata;
    endtask

    task automatic look(input int i, output logic [31:0] v);
        map_idx = 4'(i); #1; v = map_word;
    endtask

    // start access; returns at the negedge after busy clears
    task automatic access(input bit wr, input string req, input bit chk_d, input logic [31:0] dexp);
        logic [31:0] v;
        wreg(0, INIT | (wr ? RWB : 0));
        rreg(0, v); chk(req, v & BUSY, BUSY);
        @(negedge clk);
        rreg(0, v); chk(req, v & BUSY, BUSY);
        if (chk_d) begin rreg(1, v); chk(req, v, dexp); end
        @(negedge clk);
        rreg(0, v); chk(req, v & BUSY, 0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rreg(0, v); chk("R1 ctrl", v, 0);
        rreg(1, v); chk("R1 data", v, 0);
        for (int i = 0; i < 16; i++) begin look(i, v); chk("R1 ram", v, 0); end

        // R2 address load with wrap
        wreg(0, 32'h0000_0023);
        rreg(0, v); chk("R2 addr mod", v, cexp(0, 0, 0, 3));
        wreg(0, RWB | 32'h0000_0005);
        rreg(0, v); chk("R2 rw rec", v, cexp(0, 1, 0, 5));

        // R3 arm only
        wreg(0, 32'h0000_0000);
        wreg(0, INIT);
        rreg(0, v); chk("R3 arm", v, cexp(0, 0, 1, 0));
        @(negedge clk);
        rreg(0, v); chk("R3 no busy", v, cexp(0, 0, 1, 0));

        // R4 R6 R8 stream write of all words
        for (int i = 0; i < 16; i++) begin
            wreg(1, pat(i));
            rreg(1, v); chk("R8 data rb", v, pat(i));
            look(i, v); chk("R8 ram untouched", v, 0);
            access(1, "R4 busy", 0, 0);
            look(i, v); chk("R4 word", v, pat(i));
            rreg(0, v); chk("R6 incr", v, cexp(0, 1, 1, i + 1));
        end
        // R9 lookup of every word
        for (int i = 15; i >= 0; i--) begin look(i, v); chk("R9 lookup", v, pat(i)); end

        // R5 R6 stream read starting mid-RAM, wrapping
        wreg(0, 32'h0000_0005);
        wreg(0, INIT);
        for (int k = 0; k < 16; k++) begin
            access(0, "R5 read", 1, pat((5 + k) % 16));
            rreg(1, v); chk("R5 data held", v, pat((5 + k) % 16));
            rreg(0, v); chk("R6 rd incr", v, cexp(0, 0, 1, 6 + k));
        end

        // R2 R6 wrap at top via oversize field
        wreg(0, 32'h0000_003F);
        wreg(1, 32'hDEAD_BEEF);
        wreg(0, INIT);
        access(1, "R4 top", 0, 0);
        look(15, v); chk("R4 top word", v, 32'hDEAD_BEEF);
        rreg(0, v); chk("R6 wrap", v, cexp(0, 1, 1, 0));

        // R7 control write during busy ignored
        wreg(0, 32'h0000_0002);
        wreg(1, 32'hCAFE_0001);
        wreg(0, INIT);
        wreg(0, INIT | RWB);            // start, returns in first busy cycle
        wreg(0, 32'h0000_0009);         // lands while busy
        @(negedge clk);
        rreg(0, v); chk("R7 ctrl ignored", v, cexp(0, 1, 1, 3));
        look(2, v); chk("R7 write done", v, 32'hCAFE_0001);

        // R7 data write during read busy ignored
        wreg(0, 32'h0000_0004);
        wreg(0, INIT);
        wreg(0, INIT);                  // start read of word 4
        wreg(1, 32'hFFFF_FFFF);         // lands while busy
        @(negedge clk);
        rreg(1, v); chk("R7 data ignored", v, pat(4));
        rreg(0, v); chk("R7 state", v, cexp(0, 0, 1, 5));

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule